// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Word Buffer

This block receives asynchronous NRZ serial frames: a start bit, then eight or nine data bits least-significant first, then one stop bit. An external pulse of one clock arriving sixteen times per bit period paces a sampling engine. The engine confirms each start bit at mid-bit, recovers every data bit and the stop bit by a three-sample majority vote, and assembles the word in a shift register.

Each completed word moves into a two-entry buffer. The buffer keeps the ninth bit and a framing-error flag with every word, so those two status outputs always belong to the word shown at the head. A third word that arrives while both entries are occupied is dropped and raises a sticky overrun flag. While that flag is set, the receiver accepts no more words. Dropping the receive enable clears the flag, empties the buffer and returns the sampler to idle.

Top module: `nrz_rx_core`

## Requirements
- R1: After a synchronous reset, `not_empty_o` and `overrun_o` are 0.
- R2: With `nine_bit_i` = 0, a frame's eight data bits, taken first-received as bit 0, appear on `rd_data_o` with `not_empty_o` = 1, `rd_bit9_o` = 0 and `rd_ferr_o` = 0 once the stop bit has been sampled high.
- R3: With `nine_bit_i` = 1 when the frame starts, the bit received after the eighth data bit is presented on `rd_bit9_o` with that word.
- R4: A start is hunted only after the line has been seen high. A low pulse shorter than half a bit, gone by the mid-bit sample, is discarded and produces no word.
- R5: Each data bit is the majority of oversampling ticks 7, 8 and 9 of its bit period, so a line disturbance lasting one tick never alters the word.
- R6: A stop bit whose majority vote is low sets `rd_ferr_o` = 1 for that word; the data is still stored.
- R7: The buffer holds two words in arrival order. `not_empty_o` stays 1 until both have been popped with `pop_i`. Data, ninth bit and framing flag all move to the next word's values together on a pop.
- R8: A word that completes while both entries are full is lost and sets `overrun_o`; the two stored words are unchanged.
- R9: While `overrun_o` is 1, completed frames are not stored even if the buffer has been emptied.
- R10: With `rx_enable_i` = 0, the buffer is flushed, `overrun_o` is cleared and line activity produces no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line_i | input | 1 | Serial input line, idle high |
| rx_enable_i | input | 1 | Continuous receive enable |
| nine_bit_i | input | 1 | Select 9 data bits per frame |
| tick16_i | input | 1 | One-clock pulse at 16 times the bit rate |
| pop_i | input | 1 | Remove the head word from the buffer |
| rd_data_o | output | 8 | Head word data |
| rd_bit9_o | output | 1 | Ninth bit of the head word |
| rd_ferr_o | output | 1 | Framing error of the head word |
| not_empty_o | output | 1 | Buffer holds at least one word |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The overrun lockout is the hardest state to reach from the ports. Three complete frames must land before any pop. The bench must then drain both entries and send a fourth frame to show that the emptied buffer still refuses it. The stimulus sends frames back to back at the line level with no pops in between. After draining the buffer it sends one more frame and expects the buffer to stay empty, and it then cycles the enable to show the lockout lifts. Single-tick glitches are placed at the centre of a data bit, so at most one of the three votes can be disturbed.

// File: rtl/nrz_rx_pkg.sv
package nrz_rx_pkg;

  typedef struct packed {
    logic       ferr;
    logic       bit9;
    logic [7:0] data;
  } rx_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/nrz_rx_sampler.sv
module nrz_rx_sampler
  import nrz_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     nine_bit,
  input  logic     tick,
  input  logic     line_in,
  output logic     done_o,
  output rx_word_t word_o
);

  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] S_MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_PRE  = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] S_POST = CW'(OSR / 2);
  localparam logic [CW-1:0] S_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] B_NINE = BW'(DATA_W);
  localparam logic [BW-1:0] B_EIGHT = BW'(DATA_W - 1);

  logic [1:0]      sync_q;
  logic            line;
  rx_state_e       state_q;
  logic [CW-1:0]   tcnt_q;
  logic [CW-1:0]   tnext;
  logic [BW-1:0]   bcnt_q;
  logic [DATA_W:0] sr_q;
  logic            nine_q;
  logic            armed_q;
  logic            v0_q, v1_q;
  logic            maj;

  assign line  = sync_q[1];
  assign tnext = (tcnt_q == S_LAST) ? '0 : tcnt_q + 1'b1;
  assign maj   = vote3(v0_q, v1_q, line);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sr_q    <= '0;
      nine_q  <= 1'b0;
      armed_q <= 1'b0;
      v0_q    <= 1'b0;
      v1_q    <= 1'b0;
      done_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        if (state_q == ST_IDLE) begin
          if (line) begin
            armed_q <= 1'b1;
          end else if (armed_q) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            sr_q    <= '0;
            nine_q  <= nine_bit;
          end
        end else begin
          tcnt_q <= tnext;
          if (tnext == S_PRE) v0_q <= line;
          if (tnext == S_MID) v1_q <= line;
          case (state_q)
            ST_START: begin
              if (tnext == S_MID && line)  state_q <= ST_IDLE;
              else if (tnext == S_LAST)    state_q <= ST_DATA;
            end
            ST_DATA: begin
              if (tnext == S_POST) sr_q[bcnt_q] <= maj;
              if (tnext == S_LAST) begin
                if (bcnt_q == (nine_q ? B_NINE : B_EIGHT)) state_q <= ST_STOP;
                else bcnt_q <= bcnt_q + 1'b1;
              end
            end
            ST_STOP: begin
              if (tnext == S_POST) begin
                done_o       <= 1'b1;
                word_o.data  <= sr_q[7:0];
                word_o.bit9  <= nine_q & sr_q[DATA_W];
                word_o.ferr  <= ~maj;
                armed_q      <= 1'b0;
                state_q      <= ST_IDLE;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/nrz_rx_wordbuf.sv
module nrz_rx_wordbuf
  import nrz_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     push_i,
  input  rx_word_t word_i,
  input  logic     pop_i,
  output rx_word_t head_o,
  output logic     not_empty_o,
  output logic     overrun_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
  localparam logic [NW-1:0] N_FULL = NW'(DEPTH);

  rx_word_t      mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] cnt_q, cnt_n;
  logic          do_pop, do_push, room;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign room    = (cnt_q != N_FULL) || do_pop;
  assign do_push = enable && push_i && !overrun_o && room;

  always_comb begin
    cnt_n = cnt_q;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push && !rst) mem[wr_q] <= word_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      wr_q        <= '0;
      rd_q        <= '0;
      cnt_q       <= '0;
      not_empty_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      cnt_q       <= cnt_n;
      not_empty_o <= (cnt_n != '0);
      if (do_push) wr_q <= (wr_q == P_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == P_LAST) ? '0 : rd_q + 1'b1;
      if (push_i && !overrun_o && !room) overrun_o <= 1'b1;
    end
  end

  assign head_o = mem[rd_q];

endmodule

// File: rtl/nrz_rx_core.sv
module nrz_rx_core
  import nrz_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line_i,
  input  logic       rx_enable_i,
  input  logic       nine_bit_i,
  input  logic       tick16_i,
  input  logic       pop_i,
  output logic [7:0] rd_data_o,
  output logic       rd_bit9_o,
  output logic       rd_ferr_o,
  output logic       not_empty_o,
  output logic       overrun_o
);

  logic     frm_done;
  rx_word_t frm_word;
  rx_word_t head;

  nrz_rx_sampler #(.OSR(OSR), .DATA_W(DATA_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .enable   (rx_enable_i),
    .nine_bit (nine_bit_i),
    .tick     (tick16_i),
    .line_in  (rx_line_i),
    .done_o   (frm_done),
    .word_o   (frm_word)
  );

  nrz_rx_wordbuf #(.DEPTH(DEPTH)) u_buf (
    .clk         (clk),
    .rst         (rst),
    .enable      (rx_enable_i),
    .push_i      (frm_done),
    .word_i      (frm_word),
    .pop_i       (pop_i),
    .head_o      (head),
    .not_empty_o (not_empty_o),
    .overrun_o   (overrun_o)
  );

  assign rd_data_o = head.data;
  assign rd_bit9_o = head.bit9;
  assign rd_ferr_o = head.ferr;

endmodule

// File: rtl/nrz_rx_core_chk.sv
module nrz_rx_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_enable_i,
  input logic       pop_i,
  input logic       frm_done,
  input logic [7:0] rd_data_o,
  input logic       rd_bit9_o,
  input logic       rd_ferr_o,
  input logic       not_empty_o,
  input logic       overrun_o
);

  // R10
  a_r10_flush_on_disable: assert property (@(posedge clk) disable iff (rst)
    !rx_enable_i |=> (!not_empty_o && !overrun_o));

  // R9
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && rx_enable_i) |=> overrun_o);

  // R8
  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> ($past(frm_done) && $past(not_empty_o)));

  // R7
  a_r7_hold_until_pop: assert property (@(posedge clk) disable iff (rst)
    (not_empty_o && !pop_i && rx_enable_i) |=> not_empty_o);

  // R7
  a_r7_head_stable: assert property (@(posedge clk) disable iff (rst)
    (not_empty_o && !pop_i && rx_enable_i) |=>
      ($stable(rd_data_o) && $stable(rd_bit9_o) && $stable(rd_ferr_o)));

endmodule

bind nrz_rx_core nrz_rx_core_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .rx_enable_i (rx_enable_i),
  .pop_i       (pop_i),
  .frm_done    (frm_done),
  .rd_data_o   (rd_data_o),
  .rd_bit9_o   (rd_bit9_o),
  .rd_ferr_o   (rd_ferr_o),
  .not_empty_o (not_empty_o),
  .overrun_o   (overrun_o)
);

// File: tb/nrz_rx_core_tb_top.sv
module nrz_rx_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line_i = 1'b1;
  logic       rx_enable_i = 1'b0;
  logic       nine_bit_i = 1'b0;
  logic       tick16_i = 1'b0;
  logic       pop_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_bit9_o, rd_ferr_o, not_empty_o, overrun_o;

  int checks = 0;
  int errors = 0;

  nrz_rx_core dut_i (
    .clk(clk), .rst(rst), .rx_line_i(rx_line_i), .rx_enable_i(rx_enable_i),
    .nine_bit_i(nine_bit_i), .tick16_i(tick16_i), .pop_i(pop_i),
    .rd_data_o(rd_data_o), .rd_bit9_o(rd_bit9_o), .rd_ferr_o(rd_ferr_o),
    .not_empty_o(not_empty_o), .overrun_o(overrun_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      for (int k = 0; k < TICK_DIV; k++) begin
        @(negedge clk);
        tick16_i = (k == 0);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit nine, input logic stop_v,
                            input int glitch_bit = -1);
    rx_line_i = 1'b0;
    wait_clks(BIT_CLKS);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx_line_i = d[i];
      if (i == glitch_bit) begin
        wait_clks(BIT_CLKS / 2 - 2);
        rx_line_i = ~d[i];
        wait_clks(TICK_DIV);
        rx_line_i = d[i];
        wait_clks(BIT_CLKS / 2 + 2 - TICK_DIV);
      end else begin
        wait_clks(BIT_CLKS);
      end
    end
    rx_line_i = stop_v;
    wait_clks(BIT_CLKS);
    rx_line_i = 1'b1;
    wait_clks(BIT_CLKS);
  endtask

  task automatic do_pop();
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  task automatic cycle_enable();
    rx_enable_i = 1'b0;
    wait_clks(2);
    rx_enable_i = 1'b1;
    wait_clks(BIT_CLKS);
  endtask

  task automatic t_reset();
    check("R1 not_empty after reset", not_empty_o, 0);
    check("R1 overrun after reset", overrun_o, 0);
  endtask

  task automatic t_eight_bit();
    nine_bit_i = 1'b0;
    send_frame(9'h0A5, 0, 1'b1);
    check("R2 not_empty", not_empty_o, 1);
    check("R2 data", rd_data_o, 8'hA5);
    check("R2 bit9", rd_bit9_o, 0);
    check("R2 ferr", rd_ferr_o, 0);
    do_pop();
    check("R7 empty after pop", not_empty_o, 0);
  endtask

  task automatic t_nine_bit();
    nine_bit_i = 1'b1;
    send_frame(9'h13C, 1, 1'b1);
    check("R3 data", rd_data_o, 8'h3C);
    check("R3 bit9", rd_bit9_o, 1);
    do_pop();
    nine_bit_i = 1'b0;
  endtask

  task automatic t_start_glitch();
    rx_line_i = 1'b0;
    wait_clks(2 * TICK_DIV);
    rx_line_i = 1'b1;
    wait_clks(12 * BIT_CLKS);
    check("R4 short start rejected", not_empty_o, 0);
    send_frame(9'h05A, 0, 1'b1);
    check("R4 frame after glitch", rd_data_o, 8'h5A);
    do_pop();
  endtask

  task automatic t_vote();
    send_frame(9'h0C3, 0, 1'b1, 2);
    check("R5 glitch on zero bit", rd_data_o, 8'hC3);
    do_pop();
    send_frame(9'h0C3, 0, 1'b1, 7);
    check("R5 glitch on one bit", rd_data_o, 8'hC3);
    do_pop();
  endtask

  task automatic t_ferr();
    send_frame(9'h081, 0, 1'b0);
    check("R6 ferr set", rd_ferr_o, 1);
    check("R6 data kept", rd_data_o, 8'h81);
    do_pop();
  endtask

  task automatic t_two_deep();
    nine_bit_i = 1'b1;
    send_frame(9'h155, 1, 1'b1);
    send_frame(9'h0AA, 1, 1'b0);
    check("R7 first data", rd_data_o, 8'h55);
    check("R7 first bit9", rd_bit9_o, 1);
    check("R7 first ferr", rd_ferr_o, 0);
    do_pop();
    check("R7 second data", rd_data_o, 8'hAA);
    check("R7 second bit9", rd_bit9_o, 0);
    check("R7 second ferr", rd_ferr_o, 1);
    check("R7 still not empty", not_empty_o, 1);
    do_pop();
    check("R7 empty after two pops", not_empty_o, 0);
    nine_bit_i = 1'b0;
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 0, 1'b1);
    check("R8 no overrun at one", overrun_o, 0);
    send_frame(9'h022, 0, 1'b1);
    check("R8 no overrun at full", overrun_o, 0);
    send_frame(9'h033, 0, 1'b1);
    check("R8 overrun set", overrun_o, 1);
    check("R8 first kept", rd_data_o, 8'h11);
    do_pop();
    check("R8 second kept", rd_data_o, 8'h22);
    do_pop();
    check("R8 third lost", not_empty_o, 0);
    send_frame(9'h044, 0, 1'b1);
    check("R9 blocked while overrun", not_empty_o, 0);
    check("R9 overrun sticky", overrun_o, 1);
    cycle_enable();
    check("R10 overrun cleared", overrun_o, 0);
    send_frame(9'h066, 0, 1'b1);
    check("R10 receive resumes", rd_data_o, 8'h66);
    do_pop();
  endtask

  task automatic t_disable();
    send_frame(9'h077, 0, 1'b1);
    send_frame(9'h088, 0, 1'b1);
    check("R10 buffered before flush", not_empty_o, 1);
    rx_enable_i = 1'b0;
    wait_clks(2);
    check("R10 flushed", not_empty_o, 0);
    send_frame(9'h099, 0, 1'b1);
    check("R10 ignored while off", not_empty_o, 0);
    rx_enable_i = 1'b1;
    wait_clks(BIT_CLKS);
    check("R10 nothing after re-enable", not_empty_o, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    wait_clks(5);
    rst = 1'b0;
    wait_clks(1);
    t_reset();
    rx_enable_i = 1'b1;
    wait_clks(BIT_CLKS);
    t_eight_bit();
    t_nine_bit();
    t_start_glitch();
    t_vote();
    t_ferr();
    t_two_deep();
    t_overrun();
    t_disable();
    finish_run();
  end

endmodule